// File: doc/BRIEF.md
# Converter Serial Readout Sequencer

This block is the digital side of a 16-bit converter's three-wire serial port. It steps through three phases: a conversion phase of fixed length, a sleep phase that holds the finished result, and a readout phase. In the readout phase the result leaves the block one bit at a time on a three-state data line. A host drives an active-low select and a serial clock. Both come into a fast system clock through synchronizers, and the block acts on edges of the synchronized versions. A cycle counter stands in for the analog conversion time. When the counter expires, the block captures the word on its result input.

The host can read with the serial clock idling high or idling low. A readout ends on the sixteenth falling clock edge or on a rising edge of select, and either one starts a new conversion. While select is low and no readout is in progress, the data line reports whether a conversion is still running. With select tied low and the clock idling low, the block goes from conversion straight into readout. A low-power flag is raised while the block sleeps with select high.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset the phase order is always conversion, then sleep (or readout directly, see R11), then readout, then conversion again.
- R2: A conversion lasts exactly CONV_CYCLES system clock cycles from its start. No activity on select or the serial clock ends it early.
- R3: The block leaves sleep for readout only when the synchronized select and serial clock are both low in the same cycle.
- R4: On entering readout the data line carries result bit 15. Each later falling serial clock edge presents the next lower bit, so the word goes out MSB first in straight binary.
- R5: The sixteenth falling serial clock edge of a readout ends it and starts a new conversion. With a clock that idles high this is the seventeenth clock pulse.
- R6: A rising edge on select during readout aborts it at once and starts a new conversion. Bits not yet shifted out are discarded, and the next readout returns the next conversion's word.
- R7: With select low outside readout, the data line drives 1 during conversion and 0 during sleep.
- R8: The output enable is low (line high-impedance) whenever the synchronized select is high.
- R9: Serial clock edges during conversion have no effect on the data line or on the conversion length.
- R10: The captured result is held unchanged through a sleep of any length, whatever the result input does meanwhile.
- R11: If select and clock are both low when a conversion ends, the block enters readout directly and shows bit 15. The low-power flag stays low.
- R12: The low-power flag is high only in sleep with select high.
- R13: During and right after reset, with select high, the output enable and the low-power flag are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cs_n_i | input | 1 | Active-low select from the host (asynchronous) |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| result_i | input | DATA_W | Converter result, captured when the conversion timer expires |
| sdo_o | output | 1 | Serial data / conversion status value |
| sdo_oe_o | output | 1 | Drive enable for the data line; low means high-impedance |
| low_power_o | output | 1 | Raised while sleeping with select high |

## Verification
The hardest states to reach are the ones that depend on where the host's edges fall relative to the end of a conversion. The 2-wire entry needs select and clock already low, and held low, through the cycle in which the timer expires. An abort needs a select rising edge partway through the word. The bench reaches these by parking the pins in a chosen level before the conversion ends and waiting past the known conversion length. It picks the clock polarity, the readout length and the way each readout ends at random. The first conversion is also run under rapid random toggling of both inputs, to show that its length and status do not move.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_CONVERT = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_DOUT    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb pipe_d = {pipe_q[STAGES-2:0], din[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL[b]}};
      else        pipe_q <= pipe_d;
    end

    assign dout[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
  parameter int unsigned CYCLES = 6_660_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    done  = run && (cnt_q == LAST);
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: expiry is a single-cycle pulse; the sequencer must leave conversion on it
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/adc_seq_shifter.sv
`timescale 1ns/1ps
module adc_seq_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = din;
    else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign msb = sh_q[W-1];

  // R10: the held word does not change unless loaded or shifted
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sh_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       sck_s,
  input  logic       conv_done,
  output seq_state_e state,
  output logic       load,
  output logic       shift
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             cs_d_q, sck_d_q;
  logic             cs_rise, sck_fall, both_low;

  always_comb begin
    cs_rise  = cs_s & ~cs_d_q;
    sck_fall = ~sck_s & sck_d_q;
    both_low = ~cs_s & ~sck_s;
  end

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_CONVERT: begin
        if (conv_done) begin
          load    = 1'b1;
          bit_d   = '0;
          state_d = both_low ? ST_DOUT : ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (both_low) begin
          bit_d   = '0;
          state_d = ST_DOUT;
        end
      end
      ST_DOUT: begin
        if (cs_rise) begin
          state_d = ST_CONVERT;
        end else if (sck_fall) begin
          if (bit_q == LAST_BIT) begin
            state_d = ST_CONVERT;
          end else begin
            bit_d = bit_q + 1'b1;
            shift = 1'b1;
          end
        end
      end
      default: state_d = ST_CONVERT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CONVERT;
      bit_q   <= '0;
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      cs_d_q  <= cs_s;
      sck_d_q <= sck_s;
    end
  end

  assign state = state_q;

  // R2: the host cannot cut a conversion short
  p_convert_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONVERT && !conv_done) |=> state_q == ST_CONVERT);

  // R3: readout is entered from sleep only after select and clock were both low
  p_sleep_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT && $past(state_q) == ST_SLEEP) |-> $past(!cs_s && !sck_s));

  // R5: the final falling edge closes the readout
  p_last_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT && sck_fall && !cs_rise && bit_q == LAST_BIT) |=> state_q == ST_CONVERT);

  // R6: a select rising edge aborts the readout
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOUT && cs_rise) |=> state_q == ST_CONVERT);
endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/1ps
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 6_660_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              low_power_o
);
  logic [1:0] pins_s;
  logic       cs_s, sck_s;
  logic       conv_done, load, shift, msb;
  seq_state_e state;

  adc_seq_sync #(
    .W       (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .din   ({cs_n_i, sck_i}),
    .dout  (pins_s)
  );

  assign cs_s  = pins_s[1];
  assign sck_s = pins_s[0];

  adc_seq_timer #(
    .CYCLES (CONV_CYCLES)
  ) u_timer (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .run   (state == ST_CONVERT),
    .done  (conv_done)
  );

  adc_seq_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .cs_s      (cs_s),
    .sck_s     (sck_s),
    .conv_done (conv_done),
    .state     (state),
    .load      (load),
    .shift     (shift)
  );

  adc_seq_shifter #(
    .W (DATA_W)
  ) u_shift (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .load  (load),
    .din   (result_i),
    .shift (shift),
    .msb   (msb)
  );

  always_comb begin
    sdo_oe_o    = ~cs_s;
    low_power_o = (state == ST_SLEEP) & cs_s;
    unique case (state)
      ST_DOUT:    sdo_o = msb;
      ST_CONVERT: sdo_o = 1'b1;
      default:    sdo_o = 1'b0;
    endcase
  end

  // R12: the low-power flag never coincides with a driven data line
  p_lowpower_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_power_o |-> !sdo_oe_o);
endmodule

// File: tb/adc_serial_seq_bench.sv
`timescale 1ns/1ps
module adc_serial_seq_bench;
  localparam int CONV = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sck;
  logic [15:0] conv_result;
  logic        sdo, sdo_oe, low_power;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_serial_seq #(
    .DATA_W      (16),
    .CONV_CYCLES (CONV),
    .SYNC_STAGES (2)
  ) u_adc_serial_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cs_n_i      (cs_n),
    .sck_i       (sck),
    .result_i    (conv_result),
    .sdo_o       (sdo),
    .sdo_oe_o    (sdo_oe),
    .low_power_o (low_power)
  );

  function automatic logic [15:0] top_mask(input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) m[15-i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic s);
    @(negedge clk);
    cs_n = c;
    sck  = s;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word(input bit cpol, input int nbits, input bit fall_end,
                           input bit entered, output logic [15:0] got);
    got = '0;
    if (!cpol) begin
      if (!entered) begin
        pins(1'b1, 1'b0);
        pins(1'b0, 1'b0);
      end
      for (int i = 0; i < nbits; i++) begin
        got[15-i] = sdo;
        pins(1'b0, 1'b1);
        if (i < 15 || fall_end) pins(1'b0, 1'b0);
      end
    end else begin
      pins(1'b1, 1'b1);
      pins(1'b0, 1'b1);
      check("R7 sleep status", {15'd0, sdo}, 16'd0);
      for (int i = 0; i < nbits; i++) begin
        pins(1'b0, 1'b0);
        got[15-i] = sdo;
        pins(1'b0, 1'b1);
      end
      if (nbits == 16 && fall_end) begin
        pins(1'b0, 1'b0);
        pins(1'b0, 1'b1);
      end
    end
    pins(1'b1, 1'b1);
  endtask

  task automatic after_read(input string req);
    pins(1'b0, 1'b1);
    check(req, {15'd0, sdo}, 16'd1);
    pins(1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, w;
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    cs_n = 1'b1;
    sck = 1'b0;
    conv_result = 16'hA5C3;
    repeat (5) @(negedge clk);
    // R13: reset state
    check("R13 oe in reset", {15'd0, sdo_oe}, 16'd0);
    check("R13 low_power in reset", {15'd0, low_power}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 oe after reset", {15'd0, sdo_oe}, 16'd0);

    // R2 / R9: hammer both inputs during the first conversion
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cs_n = 1'($urandom_range(0, 1));
      sck  = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    pins(1'b0, 1'b1);
    check("R2 R9 still converting", {15'd0, sdo}, 16'd1);
    check("R7 oe with select low", {15'd0, sdo_oe}, 16'd1);
    repeat (150) @(negedge clk);
    check("R1 R7 sleep after conversion", {15'd0, sdo}, 16'd0);
    check("R12 no low power with select low", {15'd0, low_power}, 16'd0);
    pins(1'b1, 1'b1);
    check("R12 low power in sleep", {15'd0, low_power}, 16'd1);
    check("R8 high-z with select high", {15'd0, sdo_oe}, 16'd0);

    // R10: change input during a long sleep
    conv_result = 16'h1234;
    repeat (500) @(negedge clk);
    check("R3 select high keeps sleep", {15'd0, low_power}, 16'd1);
    read_word(1'b0, 16, 1'b1, 1'b0, got);
    check("R4 R10 idle-low readout held", got, 16'hA5C3);
    after_read("R5 16th fall starts conversion");

    // idle-high with 17th pulse
    conv_result = 16'h8001;
    repeat (260) @(negedge clk);
    read_word(1'b1, 16, 1'b1, 1'b0, got);
    check("R4 idle-high readout", got, 16'h8001);
    after_read("R5 17th pulse starts conversion");

    // R6: abort after 5 bits, then the next word must be new
    conv_result = 16'hF0E1;
    repeat (260) @(negedge clk);
    read_word(1'b0, 5, 1'b0, 1'b0, got);
    check("R6 partial bits", got & top_mask(5), 16'hF0E1 & top_mask(5));
    after_read("R6 abort starts conversion");
    conv_result = 16'h3C5A;
    repeat (260) @(negedge clk);
    read_word(1'b1, 16, 1'b0, 1'b0, got);
    check("R6 next readout is new word", got, 16'h3C5A);
    after_read("R6 select rise after full word");

    // R11: 2-wire idle-low, select tied low
    conv_result = 16'h5A3C;
    pins(1'b0, 1'b0);
    check("R11 busy while converting", {15'd0, sdo}, 16'd1);
    repeat (260) @(negedge clk);
    check("R11 direct readout shows MSB", {15'd0, sdo}, 16'd0);
    check("R11 no low power", {15'd0, low_power}, 16'd0);
    read_word(1'b0, 16, 1'b1, 1'b1, got);
    check("R11 2-wire word", got, 16'h5A3C);
    after_read("R11 new conversion after 2-wire read");

    // random mix
    for (int k = 0; k < 24; k++) begin
      bit cpol, fend;
      int nb;
      w = 16'($urandom);
      cpol = 1'($urandom_range(0, 1));
      fend = 1'($urandom_range(0, 1));
      nb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 15)) : 16;
      conv_result = w;
      repeat (260) @(negedge clk);
      conv_result = ~w;
      read_word(cpol, nb, fend, 1'b0, got);
      check("R4 R10 random readout", got & top_mask(nb), w & top_mask(nb));
      after_read(nb < 16 ? "R6 random abort" : "R5 random end");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule